// File: doc/BRIEF.md
# Stereo Sample Buffer with Channel Routing

This block sits between a bus that writes audio samples and a pulse-width modulation output stage. It keeps two small buffers of signed 16-bit samples, one fed by a left push port and one by a right push port. Each strobe of the sample-rate `tick` input takes at most one entry from each buffer. A 4-bit routing register then sends each entry to the left output, sends it to the right output, or discards it.

A second register sets how many entries each buffer uses, from 0 to 16. Values above 16 count as 16. The buffers are not ring FIFOs.

- A push stores at the write position and restarts reading at entry 0.
- A pop reads at the read position and restarts writing at entry 0.

Software fills a burst of samples, and the tick stream plays that burst back in order. Two cases are set by the house rules:

- A routing code with no defined meaning raises a sticky error flag.
- When both buffers aim at the same output on one tick, the left buffer's sample wins.

Top module: `pwm_fifo_router`

## Requirements
- R1: A synchronous active-high `rst` clears both valid strobes, both outputs, `route_err`, the routing register and the size register, and empties both buffers.
- R2: A register write with `reg_sel`=0 loads `reg_wdata[3:0]` into the routing register. A write with `reg_sel`=1 loads `reg_wdata[4:0]` into the size register. The usable size is the smaller of that value and 16. A push stores its data at the buffer's write position, advances that position and sets the read position to 0. A push made when the write position has reached the usable size is ignored.
- R3: On a tick, a buffer pops only while its read position is below the usable size. A pop that is routed to an output raises that output's valid strobe on the following cycle and presents the entry at the read position. Without a tick, both valid strobes stay low.
- R4: Routing bits [1:0] control the left buffer: 1 sends it to `left_out`, 2 sends it to `right_out`.
- R5: Routing bits [3:2] control the right buffer: 1 sends it to `right_out`, 2 sends it to `left_out`.
- R6: Routing value 0 mutes a buffer. On a tick it still advances its read position, but it raises no strobe.
- R7: Every pop sets that buffer's write position to 0, so the next push lands in entry 0.
- R8: Routing value 3 does not pop and leaves both positions unchanged. A tick seen with that value sets `route_err`, which stays set until reset.
- R9: When both buffers pop towards the same output on one tick, that output carries the left buffer's entry. The right buffer's entry is dropped, although its read position still advances.
- R10: A push on a buffer in the same cycle as a pop of that buffer is ignored.
- R11: A size value above 16 behaves exactly as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the routing register, 1 selects the size register |
| reg_wdata | input | 8 | Register write data |
| l_push | input | 1 | Push into the left buffer |
| l_data | input | 16 | Left sample to push |
| r_push | input | 1 | Push into the right buffer |
| r_data | input | 16 | Right sample to push |
| tick | input | 1 | Sample-rate strobe |
| left_out | output | 16 | Signed left output sample |
| left_valid | output | 1 | `left_out` was updated this cycle |
| right_out | output | 16 | Signed right output sample |
| right_valid | output | 1 | `right_out` was updated this cycle |
| route_err | output | 1 | Sticky flag for an undefined routing code |

## Verification
The hardest conditions to reach are those where several index rules apply in one cycle:

- a push on a buffer in the same cycle as a tick that pops it;
- an undefined routing code applied while a buffer still holds unread entries;
- both buffers holding data while aimed at one output.

Directed sequences fill both buffers and change the routing register between ticks to reach each of these. Ticks are placed on the same cycle as pushes. A long random phase then mixes register writes, pushes and ticks, including out-of-range sizes. A behavioural model of positions and queues is compared with the outputs on every cycle.

// File: rtl/pwm_fifo_router.sv
module pwm_fifo_router #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic                 reg_sel,
  input  logic [7:0]           reg_wdata,
  input  logic                 l_push,
  input  logic [DW-1:0]        l_data,
  input  logic                 r_push,
  input  logic [DW-1:0]        r_data,
  input  logic                 tick,
  output logic signed [DW-1:0] left_out,
  output logic                 left_valid,
  output logic signed [DW-1:0] right_out,
  output logic                 right_valid,
  output logic                 route_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = AW + 1;

  logic [3:0]    route;
  logic [IW-1:0] fsize, lim;
  logic [IW-1:0] lwr, lrd, rwr, rrd;
  logic [DW-1:0] lmem [DEPTH];
  logic [DW-1:0] rmem [DEPTH];

  wire [1:0] lm = route[1:0];
  wire [1:0] rm = route[3:2];

  assign lim = (fsize > IW'(DEPTH)) ? IW'(DEPTH) : fsize;

  wire lpop = tick && (lrd < lim) && (lm != 2'd3);
  wire rpop = tick && (rrd < lim) && (rm != 2'd3);
  wire lwok = l_push && !lpop && (lwr < lim);
  wire rwok = r_push && !rpop && (rwr < lim);

  wire l_to_l = lpop && (lm == 2'd1);
  wire l_to_r = lpop && (lm == 2'd2);
  wire r_to_r = rpop && (rm == 2'd1) && !l_to_r;
  wire r_to_l = rpop && (rm == 2'd2) && !l_to_l;

  wire [DW-1:0] lhead = lmem[lrd[AW-1:0]];
  wire [DW-1:0] rhead = rmem[rrd[AW-1:0]];

  always_ff @(posedge clk) begin
    if (lwok) lmem[lwr[AW-1:0]] <= l_data;
    if (rwok) rmem[rwr[AW-1:0]] <= r_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route       <= '0;
      fsize       <= '0;
      lwr         <= '0;
      lrd         <= '0;
      rwr         <= '0;
      rrd         <= '0;
      left_out    <= '0;
      right_out   <= '0;
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
      route_err   <= 1'b0;
    end else begin
      if (reg_we && !reg_sel) route <= reg_wdata[3:0];
      if (reg_we &&  reg_sel) fsize <= reg_wdata[IW-1:0];

      if (tick && (lm == 2'd3 || rm == 2'd3)) route_err <= 1'b1;

      left_valid  <= l_to_l || r_to_l;
      right_valid <= l_to_r || r_to_r;
      if (l_to_l)      left_out <= lhead;
      else if (r_to_l) left_out <= rhead;
      if (l_to_r)      right_out <= lhead;
      else if (r_to_r) right_out <= rhead;

      if (lpop) begin
        lrd <= lrd + 1'b1;
        lwr <= '0;
      end else if (lwok) begin
        lwr <= lwr + 1'b1;
        lrd <= '0;
      end

      if (rpop) begin
        rrd <= rrd + 1'b1;
        rwr <= '0;
      end else if (rwok) begin
        rwr <= rwr + 1'b1;
        rrd <= '0;
      end
    end
  end

  p_valid_needs_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (left_valid || right_valid) |-> $past(tick));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    route_err |=> route_err);

  p_undef_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && lm == 2'd3 && !l_push) |=> ($stable(lrd) && $stable(lwr)));

  p_pop_clears_wr_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && lrd < lim && lm != 2'd3) |=> (lwr == '0));

  p_muted_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && lm == 2'd0 && rm == 2'd0) |=> (!left_valid && !right_valid));

  p_wr_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (lwr <= IW'(DEPTH)) && (rwr <= IW'(DEPTH)));

  p_left_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && lm == 2'd1 && rm == 2'd2 && lrd < lim) |=> (left_out == $past(lhead)));
endmodule

// File: tb/tb_pwm_fifo_router.sv
module tb_pwm_fifo_router;
  localparam int CLK = 10;

  logic clk = 0, rst = 1;
  logic reg_we = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic l_push = 0, r_push = 0, tick = 0;
  logic [15:0] l_data = 0, r_data = 0;
  logic signed [15:0] left_out, right_out;
  logic left_valid, right_valid, route_err;

  pwm_fifo_router dut (.*);

  always #(CLK/2) clk = ~clk;

  int total = 0, bad = 0;
  int m_route = 0, m_size = 0;
  int lq[16], rq[16];
  int lw = 0, lr = 0, rw = 0, rr = 0;
  bit e_lv = 0, e_rv = 0, e_err = 0;
  logic [15:0] e_lo = 0, e_ro = 0;
  bit done = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " left_valid"}, 16'(left_valid), 16'(e_lv));
    chk({tag, " right_valid"}, 16'(right_valid), 16'(e_rv));
    chk({tag, " route_err R8"}, 16'(route_err), 16'(e_err));
    if (e_lv) chk({tag, " left_out"}, left_out, e_lo);
    if (e_rv) chk({tag, " right_out"}, right_out, e_ro);
  endtask

  task automatic step(string tag, bit lp, logic [15:0] ld, bit rp, logic [15:0] rd,
                      bit tk, bit we = 0, bit sel = 0, logic [7:0] wd = 0);
    int lim, lm, rm;
    bit lpop, rpop, nl, nr;
    l_push = lp; l_data = ld; r_push = rp; r_data = rd; tick = tk;
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    @(posedge clk);
    lim = (m_size > 16) ? 16 : m_size;
    lm = m_route & 3; rm = (m_route >> 2) & 3;
    if (tk && (lm == 3 || rm == 3)) e_err = 1;
    lpop = tk && lr < lim && lm != 3;
    rpop = tk && rr < lim && rm != 3;
    nl = 0; nr = 0;
    if (lpop && lm == 1) begin e_lo = 16'(lq[lr]); nl = 1; end
    if (lpop && lm == 2) begin e_ro = 16'(lq[lr]); nr = 1; end
    if (rpop && rm == 1 && !nr) begin e_ro = 16'(rq[rr]); nr = 1; end
    if (rpop && rm == 2 && !nl) begin e_lo = 16'(rq[rr]); nl = 1; end
    e_lv = nl; e_rv = nr;
    if (lpop) begin lr++; lw = 0; end
    else if (lp && lw < lim) begin lq[lw] = ld; lw++; lr = 0; end
    if (rpop) begin rr++; rw = 0; end
    else if (rp && rw < lim) begin rq[rw] = rd; rw++; rr = 0; end
    if (we && !sel) m_route = wd & 15;
    if (we && sel) m_size = wd & 31;
    @(negedge clk);
    l_push = 0; r_push = 0; tick = 0; reg_we = 0;
    compare(tag);
  endtask

  task automatic fill(string tag, int n, int base);
    for (int i = 0; i < n; i++) step(tag, 1, 16'(base + i), 1, 16'(base + 16'h100 + i), 0);
  endtask

  task automatic ticks(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #(CLK * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin lq[i] = 0; rq[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    compare("R1 reset");
    chk("R1 left_out", left_out, 0);
    chk("R1 right_out", right_out, 0);
    ticks("R1 size zero", 2);

    step("R2 size", 0, 0, 0, 0, 0, 1, 1, 8'd4);
    step("R2 route", 0, 0, 0, 0, 0, 1, 0, 8'b0101);
    fill("R2 fill", 5, 16'h1000);
    ticks("R3 R4 R5 straight", 5);
    fill("R7 refill", 2, 16'h2000);
    ticks("R7 after refill", 3);

    step("R4 cross", 0, 0, 0, 0, 0, 1, 0, 8'b1010);
    fill("R5 fill", 3, 16'h3000);
    ticks("R4 R5 cross", 4);

    step("R6 mute", 0, 0, 0, 0, 0, 1, 0, 8'b0000);
    fill("R6 fill", 3, 16'h4000);
    ticks("R6 muted", 2);
    step("R6 unmute", 0, 0, 0, 0, 0, 1, 0, 8'b0101);
    ticks("R6 rest", 3);

    fill("R8 fill", 3, 16'h5000);
    step("R8 undef", 0, 0, 0, 0, 0, 1, 0, 8'b1111);
    ticks("R8 undef tick", 2);
    step("R8 back", 0, 0, 0, 0, 0, 1, 0, 8'b0101);
    ticks("R8 resume", 4);

    step("R9 same left", 0, 0, 0, 0, 0, 1, 0, 8'b1001);
    fill("R9 fill", 2, 16'h6000);
    ticks("R9 left wins", 3);
    step("R9 same right", 0, 0, 0, 0, 0, 1, 0, 8'b0110);
    fill("R9 fill2", 2, 16'h6100);
    ticks("R9 right out", 3);

    step("R10 route", 0, 0, 0, 0, 0, 1, 0, 8'b0101);
    fill("R10 fill", 2, 16'h7000);
    step("R10 push on pop", 1, 16'hAAAA, 1, 16'hBBBB, 1);
    ticks("R10 drain", 2);
    step("R10 push idle", 1, 16'hCCCC, 1, 16'hDDDD, 1);

    step("R11 size 20", 0, 0, 0, 0, 0, 1, 1, 8'd20);
    fill("R11 fill", 18, 16'h8000);
    ticks("R11 drain", 18);

    for (int i = 0; i < 600; i++) begin
      int k = $urandom_range(0, 19);
      if (k == 0) step("mix route", 0, 0, 0, 0, $urandom_range(0, 1), 1, 0, 8'($urandom_range(0, 14)));
      else if (k == 1) step("mix size", 0, 0, 0, 0, 0, 1, 1, 8'($urandom_range(0, 31)));
      else step("mix", $urandom_range(0, 1), 16'($urandom), $urandom_range(0, 1), 16'($urandom),
                $urandom_range(0, 2) == 0);
    end
    step("R8 final", 0, 0, 0, 0, 1, 1, 0, 8'b0011);
    ticks("R8 sticky", 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule